// File: doc/BRIEF.md
# Dual-Pipe Priority Thread Issue Selector

This block sits at the issue point of an in-order multithreaded core with two execution pipes: an integer pipe and an address pipe that also carries memory operations. In every cycle each thread slot presents the two oldest predecoded instructions of its window. Each entry carries a class bit and an entry count. The selector chooses at most one instruction per pipe and reports the choice to the two pipes. Each window is told how many entries to pop.

Slots are visited in strict priority order. The dominant slot is visited first. It is named by an index input and can be switched off with a valid bit. The other slots follow in ascending index order. A slot only issues from the head of its window. It may issue a second instruction in the same cycle only when that instruction is an address instruction that directly follows an integer instruction. A pipe left free by a higher slot is back-filled by the next eligible slot whose oldest instruction needs that pipe. Because the dominant slot is always visited first with both pipes free, what it receives never depends on the other slots.

Top module: `issue_sel`

## Requirements
- R1: While rstN is low and on the first cycle after it rises, intValid and addrValid are 0.
- R2: A slot's oldest entry (entry 0) goes to the integer pipe when its class bit is 0 and to the address pipe when its class bit is 1. Slot s, entry k has its class bit at slotCls[2*s+k] and its instruction at slotInsn[(2*s+k)*INSN_W +: INSN_W].
- R3: One slot issues two entries in a cycle only when entry 0 has class 0 and entry 1 has class 1. A slot whose entries are address-then-integer or integer-then-integer issues only entry 0.
- R4: A pipe left free is given to the highest-priority eligible slot whose entry 0 needs that pipe. A slot whose entry 0 cannot issue issues nothing, even if its entry 1 would fit the free pipe.
- R5: With domValid high, slot domSlot is visited first and the remaining slots follow in ascending index. With domValid low, or with the dominant slot ineligible, the order is plain ascending index.
- R6: The pipes and the entry count that the dominant slot receives are the same whether or not any other slot is eligible.
- R7: A slot with slotActive low, or with a count of 0 (slotCount[2*s +: 2]), issues nothing.
- R8: consume[2*s +: 2] gives, in the same cycle as the inputs, the number of entries taken from slot s (0, 1 or 2). It is non-zero only for slots named on a pipe.
- R9: intValid, intSlot, intInsn, addrValid, addrSlot and addrInsn show the selection made from the inputs of the previous clock cycle.
- R10: A slot with a count of 1 issues at most one entry, whatever class bit its entry 1 position carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slotActive | input | NUM_SLOTS | Slot not suspended |
| slotCount | input | 2*NUM_SLOTS | Valid entries per slot window (0, 1, 2 or more) |
| slotCls | input | 2*NUM_SLOTS | Class per entry: 0 integer, 1 address/memory |
| slotInsn | input | 2*NUM_SLOTS*INSN_W | Predecoded instruction per entry |
| domValid | input | 1 | A dominant slot is named |
| domSlot | input | SLOT_W | Index of the dominant slot |
| consume | output | 2*NUM_SLOTS | Entries to pop per slot, this cycle |
| intValid | output | 1 | Integer pipe receives an instruction |
| intSlot | output | SLOT_W | Source slot of the integer instruction |
| intInsn | output | INSN_W | Integer instruction |
| addrValid | output | 1 | Address pipe receives an instruction |
| addrSlot | output | SLOT_W | Source slot of the address instruction |
| addrInsn | output | INSN_W | Address instruction |

## Verification
The consume counts are combinational. The bench applies each input pattern on a falling edge and reads them one nanosecond later, before the next rising edge. The pipe outputs pass through one register. They are read one nanosecond after the following rising edge. A directed case confirms that just before that edge they still show the previous selection. Paired patterns that differ only in the presence of lower slots show that the dominant slot's outcome is unchanged.

// File: rtl/issue_sel_pkg.sv
`timescale 1ns/1ps
package issue_sel_pkg;
  localparam int unsigned ISSUE_SLOTS  = 8;
  localparam int unsigned ISSUE_SLOT_W = $clog2(ISSUE_SLOTS);

  typedef enum logic {
    CLS_INT  = 1'b0,
    CLS_ADDR = 1'b1
  } insCls_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                    intGo;
    logic [ISSUE_SLOT_W-1:0] intSrc;
    logic                    addrGo;
    logic [ISSUE_SLOT_W-1:0] addrSrc;
    logic                    addrSecond;
  } pick_t;
endpackage

// File: rtl/issue_sel_rank.sv
`timescale 1ns/1ps
module issue_sel_rank #(
  parameter int unsigned NUM_SLOTS = issue_sel_pkg::ISSUE_SLOTS,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                              domValid,
  input  logic [SLOT_W-1:0]                 domSlot,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]  rankSlot
);
  // position 0 holds the dominant slot, the rest keep ascending index
  for (genvar p = 0; p < NUM_SLOTS; p++) begin : g_rank
    if (p == 0) begin : g_head
      assign rankSlot[p] = domValid ? domSlot : SLOT_W'(0);
    end else begin : g_tail
      always_comb begin
        if (!domValid)
          rankSlot[p] = SLOT_W'(p);
        else if (SLOT_W'(p - 1) < domSlot)
          rankSlot[p] = SLOT_W'(p - 1);
        else
          rankSlot[p] = SLOT_W'(p);
      end
    end
  end
endmodule

// File: rtl/issue_sel_ctrl.sv
`timescale 1ns/1ps
module issue_sel_ctrl
  import issue_sel_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = ISSUE_SLOTS,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0]              slotActive,
  input  logic [2*NUM_SLOTS-1:0]            slotCount,
  input  logic [2*NUM_SLOTS-1:0]            slotCls,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]  rankSlot,
  output pick_t                             pick
);
  logic [NUM_SLOTS-1:0] eligible;
  logic [NUM_SLOTS-1:0] headIsAddr;
  logic [NUM_SLOTS-1:0] pairOk;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign eligible[s]   = slotActive[s] && (slotCount[2*s +: 2] != 2'd0);
    assign headIsAddr[s] = (insCls_e'(slotCls[2*s]) == CLS_ADDR);
    assign pairOk[s]     = (slotCount[2*s +: 2] >= 2'd2)
                           && (insCls_e'(slotCls[2*s])   == CLS_INT)
                           && (insCls_e'(slotCls[2*s+1]) == CLS_ADDR);
  end

  // strict priority walk; a slot only ever issues from its head
  always_comb begin
    logic intFree;
    logic addrFree;
    logic [SLOT_W-1:0] s;
    pick     = '0;
    intFree  = 1'b1;
    addrFree = 1'b1;
    for (int p = 0; p < NUM_SLOTS; p++) begin
      s = rankSlot[p];
      if (eligible[s]) begin
        if (!headIsAddr[s]) begin
          if (intFree) begin
            pick.intGo  = 1'b1;
            pick.intSrc = ISSUE_SLOT_W'(s);
            intFree     = 1'b0;
            if (pairOk[s] && addrFree) begin
              pick.addrGo     = 1'b1;
              pick.addrSrc    = ISSUE_SLOT_W'(s);
              pick.addrSecond = 1'b1;
              addrFree        = 1'b0;
            end
          end
        end else if (addrFree) begin
          pick.addrGo  = 1'b1;
          pick.addrSrc = ISSUE_SLOT_W'(s);
          addrFree     = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/issue_sel_dp.sv
`timescale 1ns/1ps
module issue_sel_dp
  import issue_sel_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = ISSUE_SLOTS,
  parameter int unsigned INSN_W    = 32,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  pick_t                           pick,
  input  logic [2*NUM_SLOTS*INSN_W-1:0]   slotInsn,
  output logic [2*NUM_SLOTS-1:0]          consume,
  output logic                            intValid,
  output logic [SLOT_W-1:0]               intSlot,
  output logic [INSN_W-1:0]               intInsn,
  output logic                            addrValid,
  output logic [SLOT_W-1:0]               addrSlot,
  output logic [INSN_W-1:0]               addrInsn
);
  logic [SLOT_W-1:0] intSrc;
  logic [SLOT_W-1:0] addrSrc;
  logic [INSN_W-1:0] intWord;
  logic [INSN_W-1:0] addrWord;

  assign intSrc  = SLOT_W'(pick.intSrc);
  assign addrSrc = SLOT_W'(pick.addrSrc);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pop
    logic hitInt;
    logic hitAddr;
    assign hitInt  = pick.intGo  && (intSrc  == SLOT_W'(s));
    assign hitAddr = pick.addrGo && (addrSrc == SLOT_W'(s));
    assign consume[2*s +: 2] = {1'b0, hitInt} + {1'b0, hitAddr};
  end

  assign intWord  = slotInsn[(2*intSrc)*INSN_W +: INSN_W];
  assign addrWord = slotInsn[(2*addrSrc + {{(SLOT_W){1'b0}}, pick.addrSecond})*INSN_W +: INSN_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intValid  <= 1'b0;
      intSlot   <= '0;
      intInsn   <= '0;
      addrValid <= 1'b0;
      addrSlot  <= '0;
      addrInsn  <= '0;
    end else begin
      intValid  <= pick.intGo;
      intSlot   <= pick.intGo ? intSrc : '0;
      intInsn   <= pick.intGo ? intWord : '0;
      addrValid <= pick.addrGo;
      addrSlot  <= pick.addrGo ? addrSrc : '0;
      addrInsn  <= pick.addrGo ? addrWord : '0;
    end
  end
endmodule

// File: rtl/issue_sel.sv
`timescale 1ns/1ps
module issue_sel
  import issue_sel_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = ISSUE_SLOTS,
  parameter int unsigned INSN_W    = 32,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_SLOTS-1:0]            slotActive,
  input  logic [2*NUM_SLOTS-1:0]          slotCount,
  input  logic [2*NUM_SLOTS-1:0]          slotCls,
  input  logic [2*NUM_SLOTS*INSN_W-1:0]   slotInsn,
  input  logic                            domValid,
  input  logic [SLOT_W-1:0]               domSlot,
  output logic [2*NUM_SLOTS-1:0]          consume,
  output logic                            intValid,
  output logic [SLOT_W-1:0]               intSlot,
  output logic [INSN_W-1:0]               intInsn,
  output logic                            addrValid,
  output logic [SLOT_W-1:0]               addrSlot,
  output logic [INSN_W-1:0]               addrInsn
);
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] rankSlot;
  pick_t pick;

  issue_sel_rank #(.NUM_SLOTS(NUM_SLOTS)) u_rank (
    .domValid (domValid),
    .domSlot  (domSlot),
    .rankSlot (rankSlot)
  );

  issue_sel_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .slotActive (slotActive),
    .slotCount  (slotCount),
    .slotCls    (slotCls),
    .rankSlot   (rankSlot),
    .pick       (pick)
  );

  issue_sel_dp #(.NUM_SLOTS(NUM_SLOTS), .INSN_W(INSN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pick      (pick),
    .slotInsn  (slotInsn),
    .consume   (consume),
    .intValid  (intValid),
    .intSlot   (intSlot),
    .intInsn   (intInsn),
    .addrValid (addrValid),
    .addrSlot  (addrSlot),
    .addrInsn  (addrInsn)
  );
endmodule

// File: rtl/issue_sel_chk.sv
`timescale 1ns/1ps
module issue_sel_chk #(
  parameter int unsigned NUM_SLOTS = issue_sel_pkg::ISSUE_SLOTS,
  parameter int unsigned INSN_W    = 32,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [NUM_SLOTS-1:0]            slotActive,
  input logic [2*NUM_SLOTS-1:0]          slotCount,
  input logic [2*NUM_SLOTS-1:0]          slotCls,
  input logic [2*NUM_SLOTS*INSN_W-1:0]   slotInsn,
  input logic                            domValid,
  input logic [SLOT_W-1:0]               domSlot,
  input logic [2*NUM_SLOTS-1:0]          consume,
  input logic                            intValid,
  input logic [SLOT_W-1:0]               intSlot,
  input logic [INSN_W-1:0]               intInsn,
  input logic                            addrValid,
  input logic [SLOT_W-1:0]               addrSlot,
  input logic [INSN_W-1:0]               addrInsn
);
  logic badPair;
  logic badIdle;
  int   popTotal;
  logic domInt;
  logic domAddr;

  always_comb begin
    badPair  = 1'b0;
    badIdle  = 1'b0;
    popTotal = 0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      popTotal = popTotal + int'(consume[2*s +: 2]);
      if (consume[2*s +: 2] == 2'd2 &&
          !(slotCount[2*s +: 2] >= 2'd2 && !slotCls[2*s] && slotCls[2*s+1]))
        badPair = 1'b1;
      if (consume[2*s +: 2] != 2'd0 && (!slotActive[s] || slotCount[2*s +: 2] == 2'd0))
        badIdle = 1'b1;
    end
    domInt  = domValid && slotActive[domSlot] && (slotCount[2*domSlot +: 2] != 2'd0)
              && !slotCls[2*domSlot];
    domAddr = domValid && slotActive[domSlot] && (slotCount[2*domSlot +: 2] != 2'd0)
              && slotCls[2*domSlot];
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!intValid && !addrValid)); // R1

  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    !badPair); // R3

  AST_INELIGIBLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !badIdle); // R7

  AST_POP_MATCHES_PIPES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (int'(intValid) + int'(addrValid)) == $past(popTotal)); // R8

  AST_DOM_INT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    domInt |=> (intValid && intSlot == $past(domSlot))); // R5

  AST_DOM_ADDR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    domAddr |=> (addrValid && addrSlot == $past(domSlot))); // R5
endmodule

bind issue_sel issue_sel_chk #(.NUM_SLOTS(NUM_SLOTS), .INSN_W(INSN_W)) u_chk (.*);

// File: tb/test_issue_sel.sv
`timescale 1ns/1ps
module test_issue_sel;
  localparam int N  = 8;
  localparam int W  = 32;
  localparam int SW = 3;

  typedef struct packed {
    logic [7:0]  act;
    logic [15:0] cnt;
    logic [15:0] cls;
    logic        dv;
    logic [2:0]  ds;
    logic [15:0] cons;
    logic        iv;
    logic [2:0]  is;
    logic        av;
    logic [2:0]  as;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 16'h0002, 16'h0002, 1'b0, 3'd0, 16'h0002, 1'b1, 3'd0, 1'b1, 3'd0}, // R2 R3 pair
    '{8'h01, 16'h0002, 16'h0001, 1'b0, 3'd0, 16'h0001, 1'b0, 3'd0, 1'b1, 3'd0}, // R3 addr-int
    '{8'h01, 16'h0002, 16'h0000, 1'b0, 3'd0, 16'h0001, 1'b1, 3'd0, 1'b0, 3'd0}, // R3 int-int
    '{8'h03, 16'h0006, 16'h0004, 1'b0, 3'd0, 16'h0005, 1'b1, 3'd0, 1'b1, 3'd1}, // R4 backfill
    '{8'h07, 16'h0019, 16'h0018, 1'b0, 3'd0, 16'h0011, 1'b1, 3'd0, 1'b1, 3'd2}, // R4 no passing
    '{8'h21, 16'h0801, 16'h0800, 1'b1, 3'd5, 16'h0800, 1'b1, 3'd5, 1'b1, 3'd5}, // R5 R6 with others
    '{8'h20, 16'h0800, 16'h0800, 1'b1, 3'd5, 16'h0800, 1'b1, 3'd5, 1'b1, 3'd5}, // R6 alone
    '{8'h4A, 16'h2044, 16'h2044, 1'b1, 3'd3, 16'h1040, 1'b1, 3'd6, 1'b1, 3'd3}, // R5 R4 dom addr
    '{8'h0E, 16'h0052, 16'h0016, 1'b0, 3'd0, 16'h0050, 1'b1, 3'd3, 1'b1, 3'd2}, // R7
    '{8'h01, 16'h0001, 16'h0002, 1'b0, 3'd0, 16'h0001, 1'b1, 3'd0, 1'b0, 3'd0}, // R10
    '{8'h90, 16'h8100, 16'h8100, 1'b1, 3'd2, 16'h4100, 1'b1, 3'd7, 1'b1, 3'd4}, // R5 dom ineligible
    '{8'h00, 16'h0000, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 1'b0, 3'd0}, // R7 none
    '{8'h06, 16'h0014, 16'h0014, 1'b0, 3'd0, 16'h0004, 1'b0, 3'd0, 1'b1, 3'd1}  // R5 index order
  };

  logic                 clk = 1'b0;
  logic                 rstN;
  logic [N-1:0]         slotActive;
  logic [2*N-1:0]       slotCount;
  logic [2*N-1:0]       slotCls;
  logic [2*N*W-1:0]     slotInsn;
  logic                 domValid;
  logic [SW-1:0]        domSlot;
  logic [2*N-1:0]       consume;
  logic                 intValid;
  logic [SW-1:0]        intSlot;
  logic [W-1:0]         intInsn;
  logic                 addrValid;
  logic [SW-1:0]        addrSlot;
  logic [W-1:0]         addrInsn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  issue_sel #(.NUM_SLOTS(N), .INSN_W(W)) i_issue_sel (.*);

  function automatic logic [W-1:0] insnOf(int s, int k);
    return {16'hC0DE, 8'(s), 8'(k)};
  endfunction

  function automatic string tagOf(int i);
    case (i)
      0: return "R2/R3";
      1, 2: return "R3";
      3, 4: return "R4";
      5: return "R5/R6";
      6: return "R6";
      7: return "R5/R4";
      8: return "R7";
      9: return "R10";
      10, 12: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    slotActive = v.act;
    slotCount  = v.cnt;
    slotCls    = v.cls;
    domValid   = v.dv;
    domSlot    = v.ds;
  endtask

  initial begin
    rstN = 1'b0;
    drive('0);
    for (int s = 0; s < N; s++)
      for (int k = 0; k < 2; k++)
        slotInsn[(2*s+k)*W +: W] = insnOf(s, k);
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    chk("R1 int in reset",  64'(intValid),  64'd0);
    chk("R1 addr in reset", 64'(addrValid), 64'd0);
    drive('0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 int after reset",  64'(intValid),  64'd0);
    chk("R1 addr after reset", 64'(addrValid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int   aEnt;
      v = VECS[i];
      @(negedge clk);
      drive(v);
      #1;
      chk({tagOf(i), " R8 consume"}, 64'(consume), 64'(v.cons));
      @(posedge clk); #1;
      chk({tagOf(i), " intValid"},  64'(intValid),  64'(v.iv));
      chk({tagOf(i), " addrValid"}, 64'(addrValid), 64'(v.av));
      if (v.iv) begin
        chk({tagOf(i), " intSlot"}, 64'(intSlot), 64'(v.is));
        chk({tagOf(i), " R2 intInsn"}, 64'(intInsn), 64'(insnOf(int'(v.is), 0)));
      end
      if (v.av) begin
        aEnt = (v.iv && v.is == v.as) ? 1 : 0;
        chk({tagOf(i), " addrSlot"}, 64'(addrSlot), 64'(v.as));
        chk({tagOf(i), " R2 addrInsn"}, 64'(addrInsn), 64'(insnOf(int'(v.as), aEnt)));
      end
    end

    // R9: outputs move only at the clock edge after the inputs
    @(negedge clk);
    drive(VECS[11]);
    @(negedge clk);
    drive(VECS[0]);
    #1;
    chk("R9 intValid before edge",  64'(intValid),  64'd0);
    chk("R9 addrValid before edge", 64'(addrValid), 64'd0);
    @(posedge clk); #1;
    chk("R9 intValid after edge",  64'(intValid),  64'd1);
    chk("R9 addrValid after edge", 64'(addrValid), 64'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule